// File: doc/BRIEF.md
# Dual-Target Interrupt Aggregator

This block gathers up to 32 level-sensitive, active-high interrupt requests from on-board peripherals. It steers each request onto four outputs: a normal interrupt line and a machine-check line for each of two processor cores. Each output has its own enable mask, and no exclusivity is enforced between the masks, so one request can drive several outputs at once. Nothing is latched or acknowledged. An output follows the masked source levels, one clock later, and drops once the source falls or its mask bit is cleared.

Software reaches the block through a small 32-bit register port with read and write strobes and a word address. It can read the raw source levels and read or write the four masks. It can also read a convenience register that gives the highest-numbered source that is both active and enabled in the core-0 interrupt mask. Source positions that are not wired up are forced to zero inside the block.

Top module: `irq_route_top`

## Requirements
- R1: After reset all four mask registers read 0 and irq_o and mcheck_o are 0.
- R2: A read of word 0 (byte 0x00) returns the source levels. Bit n is src_i[n] for the connected positions and 0 for the reserved positions (bit 6 and bits 17 to 31 by default).
- R3: Words 4, 5, 6 and 7 (bytes 0x10, 0x14, 0x18, 0x1C) are read/write masks. They hold, in that order, the core-0 interrupt mask, the core-1 interrupt mask, the core-0 machine-check mask and the core-1 machine-check mask. A 1 bit enables that source.
- R4: irq_o[c] equals the OR of (status AND interrupt mask c), registered one clock.
- R5: mcheck_o[c] equals the OR of (status AND machine-check mask c), registered one clock.
- R6: A source enabled in several masks asserts every matching output in the same cycle.
- R7: Outputs are level-following. One clock after a source drops or its mask bit clears, the output deasserts unless another enabled source is active.
- R8: A read of word 1 (byte 0x04) returns, in bits 4:0, the index of the highest set bit of (status AND core-0 interrupt mask). All other bits are 0. When no such bit is set the value is 0x8000_0000.
- R9: Writes to words 0 and 1 change no mask. Reads of unmapped words (2, 3, 8 to 15) return 0.
- R10: A level driven on a reserved source pin never reaches any output, even when its mask bit is set.
- R11: Read data is registered. rdata_o takes the addressed value on the clock edge where rd_en_i is high and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 2 | Interrupt line per core |
| mcheck_o | output | 2 | Machine-check line per core |

## Verification
The bench drives the reserved pins high with every mask enabled. A design that skipped the forcing would raise an output or show those bits in the status read. It sets one source in all four masks: a design that arbitrated between targets would leave an output low. It drops a source while the mask stays set, and clears a mask bit while the source stays high. A design that latched requests would keep the output asserted in both cases. It reads the encoder with no active source, with only bit 0 active and with bit 16 active. This catches an off-by-one scan, a lowest-first priority and a missing empty flag. Random mask and source patterns are checked against a bench model.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned NUM_LANES = 4;  // irq0, irq1, mck0, mck1
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned DATA_W    = 32;

  typedef enum logic [ADDR_W-1:0] {
    A_STATUS = 4'd0,
    A_TOP    = 4'd1,
    A_IMASK0 = 4'd4,
    A_IMASK1 = 4'd5,
    A_MMASK0 = 4'd6,
    A_MMASK1 = 4'd7
  } reg_addr_e;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [DATA_W-1:0]                   wdata_i,
  output logic [NUM_LANES-1:0][NUM_SRC-1:0]   masks_o
);
  logic mask_sel;
  assign mask_sel = (addr_i[ADDR_W-1:2] == '0) ? 1'b0 : (addr_i[ADDR_W-1:2] == 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masks_o <= '0;
    end else if (wr_en_i && mask_sel) begin
      masks_o[addr_i[1:0]] <= wdata_i[NUM_SRC-1:0];
    end
  end

  assert_mask_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && mask_sel) |=> (masks_o[$past(addr_i[1:0])] == $past(wdata_i[NUM_SRC-1:0])));

  assert_no_stray_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && mask_sel)) |=> $stable(masks_o));
endmodule

// File: rtl/irq_route_lane.sv
module irq_route_lane #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic               out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= 1'b0;
    else         out_o <= |(stat_i & mask_i);
  end

  assert_lane_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_i & mask_i)) |=> out_o);

  assert_lane_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|(stat_i & mask_i))) |=> !out_o);
endmodule

// File: rtl/irq_route_prio.sv
module irq_route_prio #(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  // ascending scan: last hit wins, giving the highest set bit
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 32,
  parameter logic [31:0] VALID_MASK = 32'h0001_FFBF,
  localparam int unsigned IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        irq_o,
  output logic [1:0]        mcheck_o
);
  logic [NUM_SRC-1:0]              status;
  logic [NUM_LANES-1:0][NUM_SRC-1:0] masks;
  logic [NUM_LANES-1:0]            lane_out;
  logic                            enc_found;
  logic [IDX_W-1:0]                enc_idx;
  logic [DATA_W-1:0]               rd_mux;

  // reserved positions forced low before anything else sees them
  assign status = src_i & VALID_MASK[NUM_SRC-1:0];

  irq_route_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .masks_o (masks)
  );

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    irq_route_lane #(.NUM_SRC(NUM_SRC)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stat_i (status),
      .mask_i (masks[k]),
      .out_o  (lane_out[k])
    );
  end

  assign irq_o    = lane_out[1:0];
  assign mcheck_o = lane_out[3:2];

  irq_route_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .vec_i   (status & masks[0]),
    .found_o (enc_found),
    .idx_o   (enc_idx)
  );

  always_comb begin
    case (addr_i)
      A_STATUS: rd_mux = DATA_W'(status);
      A_TOP:    rd_mux = enc_found ? DATA_W'(enc_idx) : {1'b1, {(DATA_W-1){1'b0}}};
      A_IMASK0, A_IMASK1, A_MMASK0, A_MMASK1:
                rd_mux = DATA_W'(masks[addr_i[1:0]]);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assert_status_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == A_STATUS) |=> ((rdata_o & ~VALID_MASK) == '0));

  assert_unmapped_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == 4'd2 || addr_i == 4'd3 || addr_i[3])) |=> (rdata_o == '0));

  assert_enc_highest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_found |-> ((status & masks[0]) >> enc_idx) == 1);

  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/irq_route_top_bench.sv
module irq_route_top_bench;
  localparam logic [31:0] VALID = 32'h0001_FFBF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  irq_o;
  logic [1:0]  mcheck_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl_mask [4];
  logic [31:0] rd;

  always #2 clk_i = ~clk_i;

  irq_route_top u_irq_route_top (
    .clk_i, .rst_ni, .src_i, .wr_en_i, .rd_en_i,
    .addr_i, .wdata_i, .rdata_o, .irq_o, .mcheck_o
  );

  function automatic logic [31:0] exp_enc(logic [31:0] v);
    for (int i = 31; i >= 0; i--) if (v[i]) return 32'(i);
    return 32'h8000_0000;
  endfunction

  function automatic logic [3:0] exp_outs();
    logic [31:0] s = src_i & VALID;
    return {|(s & mdl_mask[3]), |(s & mdl_mask[2]), |(s & mdl_mask[1]), |(s & mdl_mask[0])};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    if (a >= 4'd4 && a <= 4'd7) mdl_mask[a[1:0]] = d;
  endtask

  task automatic rdr(logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  // drive sources, wait for the registered outputs
  task automatic drive_src(logic [31:0] v);
    @(negedge clk_i);
    src_i = v;
    @(negedge clk_i);
  endtask

  task automatic chk_outs(string req);
    chk(req, {28'd0, mcheck_o, irq_o}, {28'd0, exp_outs()});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) mdl_mask[k] = '0;
    src_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 outputs", {28'd0, mcheck_o, irq_o}, 32'd0);
    for (int k = 4; k < 8; k++) begin
      rdr(4'(k), rd); chk("R1 mask reset", rd, 32'd0);
    end

    // R2 status with reserved bits forced
    rdr(4'd0, rd); chk("R2 status all", rd, VALID);
    drive_src(32'h0000_A5C3); rdr(4'd0, rd); chk("R2 status pattern", rd, 32'h0000_A5C3 & VALID);

    // R3 mask read back
    wr(4'd4, 32'h1234_5678); wr(4'd5, 32'hDEAD_BEEF); wr(4'd6, 32'h0F0F_0F0F); wr(4'd7, 32'hFFFF_0000);
    rdr(4'd4, rd); chk("R3 imask0", rd, 32'h1234_5678);
    rdr(4'd5, rd); chk("R3 imask1", rd, 32'hDEAD_BEEF);
    rdr(4'd6, rd); chk("R3 mmask0", rd, 32'h0F0F_0F0F);
    rdr(4'd7, rd); chk("R3 mmask1", rd, 32'hFFFF_0000);

    // R10 reserved pins with all masks enabled
    for (int k = 4; k < 8; k++) wr(4'(k), 32'hFFFF_FFFF);
    drive_src(~VALID);
    chk("R10 reserved pins silent", {28'd0, mcheck_o, irq_o}, 32'd0);
    rdr(4'd1, rd); chk("R10 encoder ignores reserved", rd, 32'h8000_0000);

    // R6 one source, all targets
    drive_src(32'h0000_0020);
    chk("R6 all four asserted", {28'd0, mcheck_o, irq_o}, 32'h0000_000F);

    // R7 source drop deasserts with mask still set
    drive_src(32'h0);
    chk("R7 drop on source low", {28'd0, mcheck_o, irq_o}, 32'd0);
    // R7 mask clear deasserts with source still high
    drive_src(32'h0000_0001);
    chk("R4 irq with source high", {30'd0, irq_o}, 32'd3);
    wr(4'd4, 32'h0);
    @(negedge clk_i);
    chk("R7 drop on mask clear", {30'd0, irq_o}, 32'd2);

    // R8 encoder corners
    wr(4'd4, 32'hFFFF_FFFF);
    drive_src(32'h0); rdr(4'd1, rd); chk("R8 encoder empty", rd, 32'h8000_0000);
    drive_src(32'h1); rdr(4'd1, rd); chk("R8 encoder bit0", rd, 32'd0);
    drive_src(32'h0001_0101); rdr(4'd1, rd); chk("R8 encoder bit16", rd, 32'd16);

    // R9 ignored writes and unmapped reads
    wr(4'd0, 32'h0); wr(4'd1, 32'h0);
    rdr(4'd4, rd); chk("R9 status write ignored", rd, 32'hFFFF_FFFF);
    rdr(4'd5, rd); chk("R9 encoder write ignored", rd, 32'hFFFF_FFFF);
    rdr(4'd2, rd); chk("R9 unmapped 2", rd, 32'd0);
    rdr(4'd3, rd); chk("R9 unmapped 3", rd, 32'd0);
    rdr(4'd9, rd); chk("R9 unmapped 9", rd, 32'd0);

    // R11 hold without read strobe
    rdr(4'd1, rd);
    drive_src(32'h0000_0004);
    chk("R11 rdata held", rdata_o, 32'd16);

    // random patterns: R4 R5
    for (int it = 0; it < 300; it++) begin
      logic [31:0] m;
      m = $urandom() & $urandom();
      wr(4'(4 + ($urandom() % 4)), m);
      drive_src($urandom() & $urandom());
      chk("R4 R5 random outputs", {28'd0, mcheck_o, irq_o}, {28'd0, exp_outs()});
      if (it % 4 == 0) begin
        rdr(4'd1, rd); chk("R8 random encoder", rd, exp_enc(src_i & VALID & mdl_mask[0]));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule